// File: doc/BRIEF.md
# Four-Channel Output Controller SPI Register File

This block is the serial configuration port of a four-channel switched-output controller. An SPI master sends 16-bit frames, one register access per frame. The upper byte gives the write flag and a 7-bit address. The lower byte gives the write data, or the readback options for a read. The block stores the global mode, the per-channel polarity and enable bits, the per-channel frequency and duty codes, and a watchdog reload value. All of these are driven out in parallel to the PWM channel logic.

A read does not answer in its own frame. The reply word is prepared when the request frame completes and is shifted out during the next chip-select frame, so a run of frames forms a one-deep pipeline. SCLK, chip select and MOSI are sampled by the system clock, which must run several times faster than SCLK. A watchdog counts system clocks in units of a prescaler. If no complete frame arrives in time, it takes the channel enables away and hands the outputs to the external per-channel input pins.

Top module: `outsw_spi_regs`

## Requirements
- R1: A frame is 16 bits, MSB first, SPI mode 0 (MOSI sampled on SCLK rising, MISO changed on SCLK falling). Bit 15 = 1 marks a write, bits 14:8 are the address, and bits 7:0 are the data. A write stores bits 7:0 only at the completion of the 16th bit, and registers never change otherwise.
- R2: The word shifted out on MISO during a frame is the reply to the previous complete frame. The reply to a write is 0x0000, and the first frame after reset returns 0x0000.
- R3: A read whose bit 7 is 1 (control readback) at a mapped address returns the register value in bits 7:0, with bits 15:8 zero. Unimplemented register bits read as 0.
- R4: A read with bit 7 = 0 (status placeholder path), or a read of an unmapped address, returns 0x0000.
- R5: Address map. 0x00 holds the mode field in bits 7:6, where 01 = normal. 0x05 holds channel i polarity-invert in bit i. 0x07 holds channel i enable in bit 4+i. 0x08+i is the channel i frequency code and 0x0C+i is the channel i duty code. 0x14 is the watchdog reload. Writes to any other address change nothing.
- R6: A frame in which chip select is released before 16 SCLK rising edges is discarded: no register changes.
- R7: After reset, all registers are zero, the mode is not normal, MISO is low, and every output is low. Enables written before normal mode is entered do not reach `ch_en_o`.
- R8: `ch_en_o[i]` equals the stored enable of channel i only while the mode is 01 and the watchdog has not expired, and is 0 otherwise. `ch_pol_o`, `ch_freq_o` and `ch_duty_o` always mirror the stored registers, with channel i in slice i.
- R9: With a watchdog value W != 0, the watchdog expires after W*TICK system clocks without a complete frame. Every complete frame restarts the count, and W = 0 disables it.
- R10: While the watchdog is expired, `ovr_o` is 1, `ch_en_o` is 0 and `ovr_level_o` follows `ch_in` one clock later. Otherwise `ovr_level_o` is 0. Any write to 0x14 clears the expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, asynchronous |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from master |
| spi_miso | output | 1 | SPI data to master |
| ch_in | input | NCH | External per-channel direct-drive levels |
| ch_en_o | output | NCH | Gated channel enables |
| ch_pol_o | output | NCH | Channel polarity-invert bits |
| ch_freq_o | output | 8*NCH | Frequency codes, channel i in bits 8i+7:8i |
| ch_duty_o | output | 8*NCH | Duty codes, channel i in bits 8i+7:8i |
| ovr_o | output | 1 | Watchdog expired, outputs follow ch_in |
| ovr_level_o | output | NCH | Direct-drive levels while expired, else 0 |

## Verification
On every cycle, the assertions check the following. The enables are gated by mode and expiry. The override levels stay zero while not expired. A disabled watchdog never expires. Stored registers move only on a completed frame, and the frame-complete strobe lasts a single cycle. Only the bench's scenarios can show the rest: the serial bit order, the one-frame reply lag, the readback path selection, the handling of unmapped addresses, discarding an aborted frame, and the watchdog timeout length and its restart by traffic.

// File: rtl/outsw_pkg.sv
package outsw_pkg;
  localparam int FRAME_BITS = 16;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;

  localparam logic [ADDR_W-1:0] A_GLB   = 7'h00;
  localparam logic [ADDR_W-1:0] A_POL   = 7'h05;
  localparam logic [ADDR_W-1:0] A_EN    = 7'h07;
  localparam logic [ADDR_W-1:0] A_FREQ0 = 7'h08;
  localparam logic [ADDR_W-1:0] A_WD    = 7'h14;

  localparam logic [1:0] MODE_NORMAL = 2'b01;
  localparam int         EN_LSB      = 4;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } req_t;
endpackage

// File: rtl/outsw_sync.sv
module outsw_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/outsw_spi_shift.sv
module outsw_spi_shift
  import outsw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk_s,
  input  logic                  cs_n_s,
  input  logic                  mosi_s,
  input  logic [FRAME_BITS-1:0] resp,
  output logic                  miso,
  output logic                  frame_done,
  output logic [FRAME_BITS-1:0] rx_word
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic                  sclk_d, cs_d;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] rx_sh, tx_sh;
  logic                  sclk_rise, sclk_fall, cs_fall;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_fall   = ~cs_n_s & cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d     <= 1'b0;
      cs_d       <= 1'b1;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      frame_done <= 1'b0;
    end else begin
      sclk_d     <= sclk_s;
      cs_d       <= cs_n_s;
      frame_done <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
        tx_sh   <= '0;
      end else if (cs_fall) begin
        bit_cnt <= '0;
        tx_sh   <= resp;
      end else begin
        if (sclk_rise && bit_cnt <= LAST) begin
          rx_sh   <= {rx_sh[FRAME_BITS-2:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST) frame_done <= 1'b1;
        end
        if (sclk_fall) tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  assign miso    = tx_sh[FRAME_BITS-1];
  assign rx_word = rx_sh;
endmodule

// File: rtl/outsw_reg_bank.sv
module outsw_reg_bank
  import outsw_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_done,
  input  logic [FRAME_BITS-1:0] rx_word,
  output logic [FRAME_BITS-1:0] resp,
  output logic [1:0]            mode,
  output logic [NCH-1:0]        pol,
  output logic [NCH-1:0]        en,
  output logic [NCH*8-1:0]      freq,
  output logic [NCH*8-1:0]      duty,
  output logic [DATA_W-1:0]     wd,
  output logic                  wd_wr
);
  localparam logic [ADDR_W-1:0] A_DUTY0 = A_FREQ0 + ADDR_W'(NCH);

  req_t              req;
  logic              wr_stb;
  logic              rd_hit;
  logic [DATA_W-1:0] rd_val;

  assign req    = req_t'(rx_word);
  assign wr_stb = frame_done & req.wr;
  assign wd_wr  = wr_stb & (req.addr == A_WD);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0;
      pol  <= '0;
      en   <= '0;
      wd   <= '0;
    end else if (wr_stb) begin
      if (req.addr == A_GLB) mode <= req.data[7:6];
      if (req.addr == A_POL) pol  <= req.data[NCH-1:0];
      if (req.addr == A_EN)  en   <= req.data[EN_LSB +: NCH];
      if (req.addr == A_WD)  wd   <= req.data;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        freq[g*8 +: 8] <= '0;
        duty[g*8 +: 8] <= '0;
      end else if (wr_stb) begin
        if (req.addr == A_FREQ0 + ADDR_W'(g)) freq[g*8 +: 8] <= req.data;
        if (req.addr == A_DUTY0 + ADDR_W'(g)) duty[g*8 +: 8] <= req.data;
      end
    end
  end

  always_comb begin
    rd_hit = 1'b1;
    rd_val = '0;
    if (req.addr == A_GLB)      rd_val = {mode, 6'b0};
    else if (req.addr == A_POL) rd_val = DATA_W'(pol);
    else if (req.addr == A_EN)  rd_val = DATA_W'(en) << EN_LSB;
    else if (req.addr == A_WD)  rd_val = wd;
    else begin
      rd_hit = 1'b0;
      for (int i = 0; i < NCH; i++) begin
        if (req.addr == A_FREQ0 + ADDR_W'(i)) begin
          rd_hit = 1'b1;
          rd_val = freq[i*8 +: 8];
        end
        if (req.addr == A_DUTY0 + ADDR_W'(i)) begin
          rd_hit = 1'b1;
          rd_val = duty[i*8 +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) resp <= '0;
    else if (frame_done) begin
      if (!req.wr && req.data[7] && rd_hit) resp <= {8'h00, rd_val};
      else                                  resp <= '0;
    end
  end
endmodule

// File: rtl/outsw_wdog.sv
module outsw_wdog #(
  parameter int TICK = 1000,
  parameter int W    = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] reload,
  input  logic         kick,
  input  logic         cfg_wr,
  output logic         expired
);
  localparam int PW = (TICK > 1) ? $clog2(TICK) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK - 1);

  logic [PW-1:0] pre;
  logic [W-1:0]  units;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre     <= '0;
      units   <= '0;
      expired <= 1'b0;
    end else if (cfg_wr || kick) begin
      pre   <= '0;
      units <= '0;
      if (cfg_wr) expired <= 1'b0;
    end else if (reload != '0 && !expired) begin
      if (pre == PRE_LAST) begin
        pre   <= '0;
        units <= units + 1'b1;
        if (units == reload - 1'b1) expired <= 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end
endmodule

// File: rtl/outsw_spi_regs.sv
module outsw_spi_regs
  import outsw_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int TICK        = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic [NCH-1:0]   ch_in,
  output logic [NCH-1:0]   ch_en_o,
  output logic [NCH-1:0]   ch_pol_o,
  output logic [NCH*8-1:0] ch_freq_o,
  output logic [NCH*8-1:0] ch_duty_o,
  output logic             ovr_o,
  output logic [NCH-1:0]   ovr_level_o
);
  logic [2:0]            pins_s;
  logic                  frame_done;
  logic [FRAME_BITS-1:0] rx_word, resp_word;
  logic [1:0]            mode_w;
  logic [NCH-1:0]        pol_w, en_w;
  logic [NCH*8-1:0]      freq_w, duty_w;
  logic [DATA_W-1:0]     wd_w;
  logic                  wd_wr, expired;

  outsw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_sclk, spi_cs_n, spi_mosi}),
    .q(pins_s)
  );

  outsw_spi_shift u_shift (
    .clk(clk), .rst(rst),
    .sclk_s(pins_s[2]), .cs_n_s(pins_s[1]), .mosi_s(pins_s[0]),
    .resp(resp_word), .miso(spi_miso),
    .frame_done(frame_done), .rx_word(rx_word)
  );

  outsw_reg_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rst(rst),
    .frame_done(frame_done), .rx_word(rx_word), .resp(resp_word),
    .mode(mode_w), .pol(pol_w), .en(en_w),
    .freq(freq_w), .duty(duty_w), .wd(wd_w), .wd_wr(wd_wr)
  );

  outsw_wdog #(.TICK(TICK), .W(DATA_W)) u_wdog (
    .clk(clk), .rst(rst),
    .reload(wd_w), .kick(frame_done), .cfg_wr(wd_wr),
    .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_en_o     <= '0;
      ch_pol_o    <= '0;
      ch_freq_o   <= '0;
      ch_duty_o   <= '0;
      ovr_o       <= 1'b0;
      ovr_level_o <= '0;
    end else begin
      ch_en_o     <= (mode_w == MODE_NORMAL && !expired) ? en_w : '0;
      ch_pol_o    <= pol_w;
      ch_freq_o   <= freq_w;
      ch_duty_o   <= duty_w;
      ovr_o       <= expired;
      ovr_level_o <= expired ? ch_in : '0;
    end
  end
endmodule

// File: rtl/outsw_spi_regs_chk.sv
module outsw_spi_regs_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] ch_en_o,
  input logic           ovr_o,
  input logic [NCH-1:0] ovr_level_o,
  input logic           frame_done,
  input logic [1:0]     mode_w,
  input logic [NCH-1:0] pol_w,
  input logic [7:0]     wd_w,
  input logic           expired
);
  p_regs_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> ($stable(pol_w) && $stable(mode_w)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  p_mode_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_w != 2'b01) |=> (ch_en_o == '0));

  p_wd_off_r9: assert property (@(posedge clk) disable iff (rst)
    (wd_w == '0) |=> !expired);

  p_ovr_gate_r10: assert property (@(posedge clk) disable iff (rst)
    ovr_o |-> (ch_en_o == '0));

  p_ovr_level_r10: assert property (@(posedge clk) disable iff (rst)
    !ovr_o |-> (ovr_level_o == '0));
endmodule

bind outsw_spi_regs outsw_spi_regs_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .ch_en_o(ch_en_o), .ovr_o(ovr_o),
  .ovr_level_o(ovr_level_o), .frame_done(frame_done), .mode_w(mode_w),
  .pol_w(pol_w), .wd_w(wd_w), .expired(expired)
);

// File: tb/test_outsw_spi_regs.sv
module test_outsw_spi_regs;
  localparam int NCH  = 4;
  localparam int TICK = 256;
  localparam int H    = 8;
  localparam int NV   = 18;

  // {request word, reply expected during that frame}
  localparam logic [31:0] VEC [NV] = '{
    {16'h8040, 16'h0000}, {16'h8505, 16'h0000}, {16'h883F, 16'h0000},
    {16'h8BC1, 16'h0000}, {16'h8C80, 16'h0000}, {16'h8FFF, 16'h0000},
    {16'h0580, 16'h0000}, {16'h0880, 16'h0005}, {16'h0B80, 16'h003F},
    {16'h0F80, 16'h00C1}, {16'h0700, 16'h00FF}, {16'h1380, 16'h0000},
    {16'h0080, 16'h0000}, {16'h9FAA, 16'h0040}, {16'h1F80, 16'h0000},
    {16'h0780, 16'h0000}, {16'h1480, 16'h00F0}, {16'h0000, 16'h0000}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [NCH-1:0] ch_in = '0;
  logic [NCH-1:0] ch_en_o, ch_pol_o, ovr_level_o;
  logic [NCH*8-1:0] ch_freq_o, ch_duty_o;
  logic ovr_o;
  int errors = 0, checks = 0;
  logic [15:0] rx;

  always #2.5 clk = ~clk;

  outsw_spi_regs #(.NCH(NCH), .TICK(TICK)) i_outsw_spi_regs (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .ch_in(ch_in), .ch_en_o(ch_en_o), .ch_pol_o(ch_pol_o),
    .ch_freq_o(ch_freq_o), .ch_duty_o(ch_duty_o), .ovr_o(ovr_o),
    .ovr_level_o(ovr_level_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_frame(input logic [15:0] tx, input int nbits, output logic [15:0] r);
    r = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int b = 15; b >= 16 - nbits; b--) begin
      mosi = tx[b];
      repeat (H) @(negedge clk);
      r = {r[14:0], miso};
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk); cs_n = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 en", 32'(ch_en_o), 0);
    chk("R7 pol", 32'(ch_pol_o), 0);
    chk("R7 freq", ch_freq_o, 0);
    chk("R7 ovr", {ovr_o, 27'd0, ovr_level_o}, 0);
    chk("R7 miso", 32'(miso), 0);
    // R7 enables without normal mode stay off
    spi_frame(16'h87F0, 16, rx);
    chk("R2 first reply", 32'(rx), 0);
    chk("R7 en before normal", 32'(ch_en_o), 0);
    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      spi_frame(VEC[i][31:16], 16, rx);
      chk($sformatf("R2/R3/R4/R5 vec%0d", i), 32'(rx), 32'(VEC[i][15:0]));
    end
    chk("R8 pol", 32'(ch_pol_o), 32'h5);
    chk("R8 en", 32'(ch_en_o), 32'hF);
    chk("R8 freq", ch_freq_o, 32'hC100003F);
    chk("R8 duty", ch_duty_o, 32'hFF000080);
    // R8 mode gating
    spi_frame(16'h8080, 16, rx);
    chk("R8 mode 10 gates en", 32'(ch_en_o), 0);
    spi_frame(16'h8040, 16, rx);
    chk("R8 normal restores en", 32'(ch_en_o), 32'hF);
    // R6 aborted frame
    spi_frame(16'h85FF, 12, rx);
    chk("R6 pol after abort", 32'(ch_pol_o), 32'h5);
    spi_frame(16'h0580, 16, rx);
    spi_frame(16'h0000, 16, rx);
    chk("R6 readback after abort", 32'(rx), 32'h0005);
    // R9 watchdog kept alive by traffic
    spi_frame(16'h9403, 16, rx);
    for (int k = 0; k < 3; k++) spi_frame(16'h0000, 16, rx);
    chk("R9 kicked", 32'(ovr_o), 0);
    repeat (600) @(negedge clk);
    chk("R9 before timeout", 32'(ovr_o), 0);
    repeat (300) @(negedge clk);
    chk("R9 after timeout", 32'(ovr_o), 1);
    chk("R10 en off", 32'(ch_en_o), 0);
    ch_in = 4'b1010;
    repeat (3) @(negedge clk);
    chk("R10 level follows", 32'(ovr_level_o), 32'hA);
    spi_frame(16'h9400, 16, rx);
    chk("R10 cleared", 32'(ovr_o), 0);
    chk("R10 level zero", 32'(ovr_level_o), 0);
    chk("R10 en back", 32'(ch_en_o), 32'hF);
    repeat (1200) @(negedge clk);
    chk("R9 disabled", 32'(ovr_o), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule